// File: doc/BRIEF.md
# Interrupt Router Indirect Register File

This block is the host-facing register file of an interrupt router with one redirection entry per input pin. A host reaches it through only two 32-bit locations: a select register that holds an index, and a data window that reads or writes the register at that index. Behind the window are a small identification register, a fixed version register, an arbitration register that mirrors the identification value, and a table of 64-bit redirection entries. Each entry spans two window indices.

Every entry holds a vector (bits 7:0), a delivery mode (10:8), a destination mode (11), a delivery-status bit (12), a polarity bit (13), a remote-IRR bit (14), a trigger-mode bit (15), a mask bit (16) and a destination (63:56). The delivery engine sets and clears remote IRR through side-band pulses. Every window write to a table entry produces two one-cycle strobes. The first asks the local controllers to refresh their trigger-mode view. The second asks the delivery engine to send the written pin at once.

Top module: `irr_route_regs`

## Requirements
- R1: Only 32-bit accesses (`req_size` = 2) to byte offset 0x00 or 0x10 respond. Any other size or offset reads as zero and writes to it change nothing.
- R2: A write to offset 0x00 stores all 32 bits, and a read returns them. The window index is bits 7:0 of that value.
- R3: Index 0x00 holds the identification value in bits 27:24, and its other bits read zero. Index 0x02 reads the same value. Writes to index 0x01 or 0x02 change nothing.
- R4: Index 0x01 reads ((NUM_PINS − 1) << 16) | 0x11, which is 0x001F0011 for 32 pins.
- R5: Index 0x10 + 2n maps to bits 31:0 of entry n, and index 0x11 + 2n maps to bits 63:32. Indices 0x03–0x0F and indices at or above 0x10 + 2·NUM_PINS read zero.
- R6: After reset, the select and identification values are zero and every entry is 0x0001000000010000 (masked).
- R7: Bits 12 and 14 of an entry ignore window writes. Bit 14 is set by `irr_set[n]` and cleared by `irr_clr[n]`, with clear winning.
- R8: In the cycle after a table write, `tmr_refresh` is high for one cycle if any entry bit other than 13 or 16 changed, and low otherwise.
- R9: In the cycle after a table write to entry n, `deliver_req` is high with `deliver_pin` = n exactly when the resulting bit 16 is 0, bit 14 is 0 and `pin_asserted[n]` is 1.
- R10: Read data appears on `rsp_rdata` in the cycle after the read request. It is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code: 0=8, 1=16, 2=32, 3=64 bits |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| pin_asserted | input | NUM_PINS | Per-pin asserted status |
| irr_set | input | NUM_PINS | Pulse that sets remote IRR of a pin |
| irr_clr | input | NUM_PINS | Pulse that clears remote IRR of a pin |
| tmr_refresh | output | 1 | Trigger-mode refresh strobe |
| deliver_req | output | 1 | Delivery-check strobe |
| deliver_pin | output | PIN_W | Pin the delivery strobe refers to |

## Verification
The bound checker watches several rules on every cycle from the ports alone. Neither strobe fires unless a valid 32-bit window write came one cycle earlier. A delivery strobe always names a pin that was asserted in the request cycle. Read data is zero after any cycle without a read. Accesses of the wrong size never cause a strobe.

The bench scenarios must show the rest, because it depends on stored state. That covers the index-to-entry layout, the reset image and the version value. It also covers write protection of the status bits while remote IRR is driven externally. Finally, it covers the difference between changes that only touch mask or polarity and changes that require a refresh.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int ENT_W      = 64;
    localparam int BIT_DSTAT  = 12;
    localparam int BIT_POL    = 13;
    localparam int BIT_RIRR   = 14;
    localparam int BIT_MASK   = 16;
    localparam int ID_LSB     = 24;

    localparam logic [ENT_W-1:0] ENTRY_RST  = 64'h0001_0000_0001_0000;
    localparam logic [ENT_W-1:0] RO_BITS    = (64'd1 << BIT_DSTAT) | (64'd1 << BIT_RIRR);
    localparam logic [ENT_W-1:0] NOREF_BITS = (64'd1 << BIT_POL) | (64'd1 << BIT_MASK);

    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_WIN  = 8'h10;
    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] IDX_ARB  = 8'h02;
    localparam logic [7:0] IDX_TBL  = 8'h10;
    localparam logic [7:0] VER_CODE = 8'h11;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_ID,
        WIN_VER,
        WIN_TBL
    } win_kind_e;

    // Merge one 32-bit half into an entry, keeping the status bits unchanged.
    function automatic logic [ENT_W-1:0] merge_half(
        input logic [ENT_W-1:0] cur,
        input logic [31:0]      data,
        input logic             upper
    );
        logic [ENT_W-1:0] wide;
        logic [ENT_W-1:0] lane;
        wide = upper ? {data, 32'h0} : {32'h0, data};
        lane = upper ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
        return (cur & (~lane | RO_BITS)) | (wide & lane & ~RO_BITS);
    endfunction

endpackage

// File: rtl/irr_bus_decode.sv
module irr_bus_decode
    import irr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              sel_rd,
    output logic              sel_wr,
    output logic              win_rd,
    output logic              win_wr
);
    logic word_ok;
    logic at_sel;
    logic at_win;

    always_comb begin
        word_ok = req_valid && (req_size == SIZE_WORD);
        at_sel  = (req_addr == ADDR_W'(OFS_SEL));
        at_win  = (req_addr == ADDR_W'(OFS_WIN));
        sel_rd  = word_ok && at_sel && !req_write;
        sel_wr  = word_ok && at_sel &&  req_write;
        win_rd  = word_ok && at_win && !req_write;
        win_wr  = word_ok && at_win &&  req_write;
    end
endmodule

// File: rtl/irr_window_map.sv
module irr_window_map
    import irr_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PIN_W    = 5
) (
    input  logic [7:0]       idx,
    output win_kind_e        kind,
    output logic             is_arb,
    output logic [PIN_W-1:0] pin,
    output logic             upper
);
    localparam int TBL_END = int'(IDX_TBL) + 2 * NUM_PINS;

    logic [7:0] rel;

    always_comb begin
        rel    = idx - IDX_TBL;
        pin    = PIN_W'(rel >> 1);
        upper  = rel[0];
        is_arb = (idx == IDX_ARB);
        if (idx == IDX_ID) begin
            kind = WIN_ID;
        end else if (idx == IDX_VER) begin
            kind = WIN_VER;
        end else if (idx == IDX_ARB) begin
            kind = WIN_ID;
        end else if ((int'(idx) >= int'(IDX_TBL)) && (int'(idx) < TBL_END)) begin
            kind = WIN_TBL;
        end else begin
            kind = WIN_NONE;
        end
    end
endmodule

// File: rtl/irr_route_regs.sv
module irr_route_regs
    import irr_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8,
    parameter int ID_W     = 4,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    output logic [31:0]         rsp_rdata,
    input  logic [NUM_PINS-1:0] pin_asserted,
    input  logic [NUM_PINS-1:0] irr_set,
    input  logic [NUM_PINS-1:0] irr_clr,
    output logic                tmr_refresh,
    output logic                deliver_req,
    output logic [PIN_W-1:0]    deliver_pin
);
    localparam logic [31:0] VER_WORD = (32'(NUM_PINS - 1) << 16) | 32'(VER_CODE);

    typedef struct packed {
        logic [NUM_PINS-1:0][ENT_W-1:0] tbl;
        logic [31:0]                    sel;
        logic [ID_W-1:0]                id;
        logic [31:0]                    rdata;
        logic                           refresh;
        logic                           deliver;
        logic [PIN_W-1:0]               dpin;
    } state_t;

    state_t s_q, s_d;

    logic             sel_rd, sel_wr, win_rd, win_wr;
    win_kind_e        w_kind;
    logic             w_is_arb;
    logic [PIN_W-1:0] w_pin;
    logic             w_upper;

    irr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .sel_rd    (sel_rd),
        .sel_wr    (sel_wr),
        .win_rd    (win_rd),
        .win_wr    (win_wr)
    );

    irr_window_map #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_map (
        .idx    (s_q.sel[7:0]),
        .kind   (w_kind),
        .is_arb (w_is_arb),
        .pin    (w_pin),
        .upper  (w_upper)
    );

    always_comb begin
        logic [ENT_W-1:0] old_e;
        logic [ENT_W-1:0] new_e;
        s_d         = s_q;
        s_d.rdata   = '0;
        s_d.refresh = 1'b0;
        s_d.deliver = 1'b0;
        s_d.dpin    = '0;
        old_e       = '0;
        new_e       = '0;

        for (int p = 0; p < NUM_PINS; p++) begin
            if (irr_set[p]) s_d.tbl[p][BIT_RIRR] = 1'b1;
            if (irr_clr[p]) s_d.tbl[p][BIT_RIRR] = 1'b0;
        end

        if (sel_wr) s_d.sel = req_wdata;
        if (sel_rd) s_d.rdata = s_q.sel;

        if (win_rd) begin
            case (w_kind)
                WIN_ID:  s_d.rdata = 32'(s_q.id) << ID_LSB;
                WIN_VER: s_d.rdata = VER_WORD;
                WIN_TBL: s_d.rdata = w_upper ? s_q.tbl[w_pin][63:32]
                                             : s_q.tbl[w_pin][31:0];
                default: s_d.rdata = '0;
            endcase
        end

        if (win_wr) begin
            if (w_kind == WIN_ID && !w_is_arb) begin
                s_d.id = req_wdata[ID_LSB +: ID_W];
            end else if (w_kind == WIN_TBL) begin
                old_e          = s_d.tbl[w_pin];
                new_e          = merge_half(old_e, req_wdata, w_upper);
                s_d.tbl[w_pin] = new_e;
                s_d.refresh    = |((old_e ^ new_e) & ~NOREF_BITS);
                s_d.deliver    = !new_e[BIT_MASK] && !new_e[BIT_RIRR] && pin_asserted[w_pin];
                s_d.dpin       = w_pin;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int p = 0; p < NUM_PINS; p++) begin
                s_q.tbl[p] <= ENTRY_RST;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_rdata   = s_q.rdata;
    assign tmr_refresh = s_q.refresh;
    assign deliver_req = s_q.deliver;
    assign deliver_pin = s_q.dpin;

endmodule

// File: rtl/irr_route_chk.sv
module irr_route_chk
    import irr_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8,
    parameter int PIN_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [1:0]          req_size,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [31:0]         rsp_rdata,
    input logic [NUM_PINS-1:0] pin_asserted,
    input logic                tmr_refresh,
    input logic                deliver_req,
    input logic [PIN_W-1:0]    deliver_pin
);
    logic                win_wr_q;
    logic [NUM_PINS-1:0] pa_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_wr_q <= 1'b0;
            pa_q     <= '0;
        end else begin
            win_wr_q <= req_valid && req_write && (req_size == SIZE_WORD)
                        && (req_addr == ADDR_W'(OFS_WIN));
            pa_q     <= pin_asserted;
        end
    end

    a_r8_refresh_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_refresh |-> win_wr_q);

    a_r9_deliver_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_req |-> win_wr_q);

    a_r9_deliver_pin_asserted: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_req |-> pa_q[deliver_pin]);

    a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (rsp_rdata == 32'h0));

    a_r1_bad_size_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != SIZE_WORD) |=> (!tmr_refresh && !deliver_req));

endmodule

bind irr_route_regs irr_route_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .PIN_W    (PIN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_size     (req_size),
    .req_addr     (req_addr),
    .rsp_rdata    (rsp_rdata),
    .pin_asserted (pin_asserted),
    .tmr_refresh  (tmr_refresh),
    .deliver_req  (deliver_req),
    .deliver_pin  (deliver_pin)
);

// File: tb/tb_irr_route_regs.sv
`timescale 1ns/1ps
module tb_irr_route_regs;
    localparam int N = 32;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_size = 2'd2;
    logic [7:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic [N-1:0]  pin_asserted = '0, irr_set = '0, irr_clr = '0;
    logic          tmr_refresh, deliver_req;
    logic [PW-1:0] deliver_pin;

    always #2 clk = ~clk;

    irr_route_regs dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .pin_asserted(pin_asserted), .irr_set(irr_set),
        .irr_clr(irr_clr), .tmr_refresh(tmr_refresh), .deliver_req(deliver_req),
        .deliver_pin(deliver_pin)
    );

    typedef struct {
        int          stamp;
        logic [31:0] rd;
        logic        rf;
        logic        dl;
        logic [PW-1:0] pn;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;

    logic [63:0] m_tbl [N];
    logic [31:0] m_sel;
    logic [3:0]  m_id;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares outputs against queued expectations.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].stamp == cyc) begin
            item_t it;
            it = q.pop_front();
            n_vec++;
            if (rsp_rdata !== it.rd || tmr_refresh !== it.rf || deliver_req !== it.dl ||
                (it.dl && deliver_pin !== it.pn)) begin
                n_bad++;
                $display("FAIL %s: rdata=%h ref=%b del=%b pin=%0d expected rdata=%h ref=%b del=%b pin=%0d",
                         it.tag, rsp_rdata, tmr_refresh, deliver_req, deliver_pin,
                         it.rd, it.rf, it.dl, it.pn);
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] idx);
        int rel;
        if (idx == 8'h00 || idx == 8'h02) return {4'h0, m_id, 24'h0};
        if (idx == 8'h01) return 32'h001F_0011;
        rel = int'(idx) - 16;
        if (rel >= 0 && rel < 2 * N)
            return rel[0] ? m_tbl[rel/2][63:32] : m_tbl[rel/2][31:0];
        return 32'h0;
    endfunction

    task automatic push(input logic [31:0] rd, input logic rf, input logic dl,
                        input logic [PW-1:0] pn, input string tag);
        item_t it;
        it.stamp = cyc + 1; it.rd = rd; it.rf = rf; it.dl = dl; it.pn = pn; it.tag = tag;
        q.push_back(it);
    endtask

    // Driver: one access, expectation computed from the requirement model.
    task automatic acc(input logic wr, input logic [7:0] addr, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
        logic [31:0] rd;
        logic rf, dl;
        logic [PW-1:0] pn;
        rd = '0; rf = 1'b0; dl = 1'b0; pn = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        if (sz == 2'd2 && addr == 8'h00) begin
            if (wr) m_sel = wd; else rd = m_sel;
        end else if (sz == 2'd2 && addr == 8'h10) begin
            if (!wr) rd = m_read(m_sel[7:0]);
            else if (m_sel[7:0] == 8'h00) m_id = wd[27:24];
            else if (m_sel[7:0] >= 8'h10 && m_sel[7:0] < 8'h50) begin
                int p;
                logic [63:0] o, nw;
                p = (int'(m_sel[7:0]) - 16) / 2;
                o = m_tbl[p];
                if (m_sel[0]) nw = {wd, o[31:0]};
                else nw = {o[63:32], (wd & ~32'h5000) | (o[31:0] & 32'h5000)};
                m_tbl[p] = nw;
                rf = ((o ^ nw) & ~64'h1_2000) != 64'h0;
                dl = !nw[16] && !nw[14] && pin_asserted[p];
                pn = PW'(p);
            end
        end
        push(rd, rf, dl, pn, tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wsel(input logic [7:0] idx);
        acc(1'b1, 8'h00, 2'd2, {24'h0, idx}, "R2");
    endtask

    task automatic rirr(input int p, input logic setv);
        @(negedge clk);
        if (setv) irr_set[p] = 1'b1; else irr_clr[p] = 1'b1;
        m_tbl[p][14] = setv;
        @(negedge clk);
        irr_set = '0; irr_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_tbl[i] = 64'h0001_0000_0001_0000;
        m_sel = '0; m_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        acc(1'b0, 8'h00, 2'd2, 0, "R6 select reset");
        acc(1'b0, 8'h10, 2'd2, 0, "R6 id reset");
        wsel(8'h10); acc(1'b0, 8'h10, 2'd2, 0, "R6 entry0 low");
        wsel(8'h4F); acc(1'b0, 8'h10, 2'd2, 0, "R6 entry31 high");
        // R2 select full width
        acc(1'b1, 8'h00, 2'd2, 32'hABCD_1201, "R2 select write");
        acc(1'b0, 8'h00, 2'd2, 0, "R2 select readback");
        acc(1'b0, 8'h10, 2'd2, 0, "R4 version via low byte");
        // R3 id / arb
        wsel(8'h00); acc(1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF, "R3 id write");
        acc(1'b0, 8'h10, 2'd2, 0, "R3 id readback");
        wsel(8'h02); acc(1'b1, 8'h10, 2'd2, 32'h0300_0000, "R3 arb write ignored");
        acc(1'b0, 8'h10, 2'd2, 0, "R3 arb mirrors id");
        wsel(8'h01); acc(1'b1, 8'h10, 2'd2, 32'h1234_5678, "R3 ver write ignored");
        acc(1'b0, 8'h10, 2'd2, 0, "R4 version value");
        // R1 bad accesses
        wsel(8'h00);
        acc(1'b1, 8'h10, 2'd1, 32'h0500_0000, "R1 narrow write");
        acc(1'b1, 8'h14, 2'd2, 32'h0500_0000, "R1 other offset write");
        acc(1'b0, 8'h10, 2'd2, 0, "R1 id unchanged");
        acc(1'b0, 8'h04, 2'd2, 0, "R1 other offset read");
        acc(1'b0, 8'h00, 2'd0, 0, "R1 byte read");
        acc(1'b0, 8'h10, 2'd3, 0, "R1 wide read");
        // R5 holes
        wsel(8'h05); acc(1'b0, 8'h10, 2'd2, 0, "R5 unused index");
        wsel(8'h50); acc(1'b0, 8'h10, 2'd2, 0, "R5 past table");
        // R7 / R8 table writes on pin 5
        wsel(8'h1A); acc(1'b1, 8'h10, 2'd2, 32'h0000_F035, "R7 R8 low write");
        acc(1'b0, 8'h10, 2'd2, 0, "R7 ro bits stay clear");
        acc(1'b1, 8'h10, 2'd2, 32'h0000_D035, "R8 polarity only");
        acc(1'b1, 8'h10, 2'd2, 32'h0001_D035, "R8 mask only");
        acc(1'b1, 8'h10, 2'd2, 32'h0001_D035, "R8 no change");
        // R9 delivery
        pin_asserted[5] = 1'b1;
        wsel(8'h1B); acc(1'b1, 8'h10, 2'd2, 32'h0700_0000, "R9 masked no deliver");
        acc(1'b0, 8'h10, 2'd2, 0, "R5 entry5 high");
        wsel(8'h1A); acc(1'b1, 8'h10, 2'd2, 32'h0000_8035, "R9 unmasked deliver");
        rirr(5, 1'b1);
        acc(1'b0, 8'h10, 2'd2, 0, "R7 rirr visible");
        acc(1'b1, 8'h10, 2'd2, 32'h0000_8036, "R9 rirr blocks");
        acc(1'b0, 8'h10, 2'd2, 0, "R7 rirr kept by write");
        rirr(5, 1'b0);
        acc(1'b1, 8'h10, 2'd2, 32'h0000_8036, "R9 redeliver after clear");
        pin_asserted[5] = 1'b0;
        acc(1'b1, 8'h10, 2'd2, 32'h0000_8037, "R9 pin not asserted");
        // pin 31 high half
        pin_asserted[31] = 1'b1;
        wsel(8'h4E); acc(1'b1, 8'h10, 2'd2, 32'h0000_0041, "R9 pin31 deliver");
        wsel(8'h4F); acc(1'b1, 8'h10, 2'd2, 32'hFF00_0000, "R8 R9 pin31 high");
        acc(1'b0, 8'h10, 2'd2, 0, "R5 entry31 high");
        // R10 idle cycle zero
        @(negedge clk); push(32'h0, 1'b0, 1'b0, '0, "R10 idle rdata");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d expectations unconsumed, expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule